// File: doc/BRIEF.md
# Configurable Register Field with Update Side-Effects

This block is a single control/status field of a register bank, held in flops. Two agents can change it. Software changes it through a write data bus with per-byte lane enables, a write strobe for the field's register and a read strobe. Hardware logic changes it through an input value and an optional write enable. The stored value is driven straight out to hardware on `hw_out`.

Parameters fix the following:
- where the field sits on the software bus, and its width;
- what a software write does to the field (load, set, clear or toggle by bit, whole-field clear or set, or nothing);
- what a software read does (nothing, clear or set);
- how hardware writes are gated;
- whether software or hardware wins a conflict;
- whether a stored one lasts for only one clock;
- the reset style, the reset polarity and the reset value.

Address decoding, read-data muxing and bus protocol handling sit outside the block. The enclosing register bank generates `sw_wr` and `sw_rd` for this field's register.

Top module: `regfld_top`

## Requirements
- R1: While reset is active (`rst` high, or low when `RST_LOW` is set), the next clock edge loads `RST_VAL` into the field. `hw_out` always shows the stored field.
- R2: With `WR_EFFECT = WR_PLAIN`, field bit k maps to bus bit `FIELD_LSB + k`, which lies in byte lane `(FIELD_LSB + k) / 8`. On a software write, bits in enabled lanes load the bus bit and bits in disabled lanes keep their value.
- R3: On a software write, within enabled lanes: `WR_SET1` ORs the bus bit into the field bit, `WR_CLR1` clears field bits whose bus bit is one, and `WR_TGL1` XORs the bus bit into the field bit. Bits in disabled lanes are unchanged.
- R4: On a software write, within enabled lanes: `WR_SET0` replaces each field bit with (field AND bus), and `WR_TGL0` replaces it with (field XNOR bus). Bits in disabled lanes are unchanged.
- R5: On any software write, whatever the lane enables, `WR_CLRALL` forces the whole field to zero and `WR_SETALL` forces it to all ones.
- R6: On a read strobe, `RD_CLR` forces the field to zero and `RD_SET` forces it to all ones.
- R7: A hardware write loads `hw_in`. It is gated by the `HW_MODE` parameter:
  - `HW_EN_HIGH`: it occurs when `hw_we` is 1.
  - `HW_EN_LOW`: it occurs when `hw_we` is 0.
  - `HW_ALWAYS`: it occurs every cycle.
  - `HW_NONE`: it never occurs.
- R8: With `PREC = PREC_SW`, when updates coincide, the software write wins over the read side-effect, which wins over the hardware write.
- R9: With `PREC = PREC_HW`, an active hardware write wins over both software updates.
- R10: With `PULSE` set, the field goes to zero on every cycle without a software write, read side-effect or hardware write, so a stored one lasts one clock.
- R11: In a cycle with no update, the field keeps its value. With `WR_NONE`, a software write is no update at all, and hardware writes are not blocked by it.
- R12: With `RST_ASYNC` set, asserting reset drives `hw_out` to `RST_VAL` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, polarity and timing set by `RST_LOW` and `RST_ASYNC` |
| sw_wdata | input | BUS_W | Software write data bus |
| sw_be | input | BUS_W/8 | Per-byte lane write enables |
| sw_wr | input | 1 | Software write strobe for this field's register |
| sw_rd | input | 1 | Software read strobe for this field's register |
| hw_in | input | FIELD_W | Hardware write value |
| hw_we | input | 1 | Hardware write enable, meaning set by `HW_MODE` |
| hw_out | output | FIELD_W | Stored field value |

## Verification
The bound checker checks these on every clock:
- reset loading;
- that a hardware write which wins the chain lands `hw_in`;
- whole-field clear or set on writes, for the configurations that have it;
- the read side-effect when no software write competes;
- the single-pulse return to zero;
- that the field holds when nothing is requested.

Only the bench scenarios can show the bit-level results of each write side-effect, because a property has no reference for them. The bench runs one instance per write mode plus several mixed configurations, under random lane enables and data. That covers:
- which lanes a field spanning three bytes takes from the bus;
- the priority order when strobes coincide;
- the asynchronous reset taking effect between clock edges.

// File: rtl/regfld_pkg.sv
package regfld_pkg;

    // Effect of a software write on the field
    typedef enum logic [3:0] {
        WR_NONE,    // software cannot write
        WR_PLAIN,   // enabled lanes load bus bits
        WR_SET1,    // OR in bus bits
        WR_CLR1,    // clear where bus bit is one
        WR_TGL1,    // XOR bus bits
        WR_SET0,    // AND with bus bits
        WR_TGL0,    // XNOR with bus bits
        WR_CLRALL,  // whole field to zero
        WR_SETALL   // whole field to ones
    } wr_effect_e;

    // Effect of a software read on the field
    typedef enum logic [1:0] {
        RD_NONE,
        RD_CLR,
        RD_SET
    } rd_effect_e;

    // Hardware write gating
    typedef enum logic [1:0] {
        HW_NONE,
        HW_ALWAYS,
        HW_EN_HIGH,
        HW_EN_LOW
    } hw_mode_e;

    typedef enum logic {
        PREC_SW,
        PREC_HW
    } prec_e;

    // Winner of the priority chain in one cycle
    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_SW,
        SRC_RD,
        SRC_HW,
        SRC_PULSE
    } src_e;

    // Update requests raised in one cycle
    typedef struct packed {
        logic sw;
        logic rd;
        logic hw;
    } req_t;

    // Next value of one field bit under a software write
    function automatic logic wr_bit(wr_effect_e m, logic q, logic b, logic en);
        logic r;
        case (m)
            WR_PLAIN:  r = en ? b : q;
            WR_SET1:   r = q | (en & b);
            WR_CLR1:   r = q & ~(en & b);
            WR_TGL1:   r = q ^ (en & b);
            WR_SET0:   r = en ? (q & b) : q;
            WR_TGL0:   r = en ? ~(q ^ b) : q;
            WR_CLRALL: r = 1'b0;
            WR_SETALL: r = 1'b1;
            default:   r = q;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regfld_sw_path.sv
// Software-write next value, one bit per field position, gated by its lane
module regfld_sw_path
    import regfld_pkg::*;
#(
    parameter int         BUS_W     = 32,
    parameter int         FIELD_LSB = 4,
    parameter int         FIELD_W   = 16,
    parameter wr_effect_e WR_EFFECT = WR_PLAIN
) (
    input  logic [FIELD_W-1:0] q,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [BUS_W/8-1:0] be,
    output logic [FIELD_W-1:0] nxt
);
    localparam int LANES = BUS_W / 8;

    for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
        localparam int POS  = FIELD_LSB + k;
        localparam int LANE = POS / 8;
        if (LANE < LANES) begin : g_in
            assign nxt[k] = wr_bit(WR_EFFECT, q[k], wdata[POS], be[LANE]);
        end else begin : g_out
            assign nxt[k] = q[k];
        end
    end
endmodule

// File: rtl/regfld_prio.sv
// Priority chain selecting the field's next value
module regfld_prio
    import regfld_pkg::*;
#(
    parameter int    FIELD_W = 16,
    parameter prec_e PREC    = PREC_SW,
    parameter bit    PULSE   = 1'b0
) (
    input  req_t               req,
    input  logic [FIELD_W-1:0] q,
    input  logic [FIELD_W-1:0] sw_val,
    input  logic [FIELD_W-1:0] rd_val,
    input  logic [FIELD_W-1:0] hw_val,
    output logic [FIELD_W-1:0] nxt
);
    src_e src;

    always_comb begin
        if (PREC == PREC_HW && req.hw) src = SRC_HW;
        else if (req.sw)               src = SRC_SW;
        else if (req.rd)               src = SRC_RD;
        else if (req.hw)               src = SRC_HW;
        else if (PULSE)                src = SRC_PULSE;
        else                           src = SRC_HOLD;
    end

    always_comb begin
        case (src)
            SRC_SW:    nxt = sw_val;
            SRC_RD:    nxt = rd_val;
            SRC_HW:    nxt = hw_val;
            SRC_PULSE: nxt = '0;
            default:   nxt = q;
        endcase
    end
endmodule

// File: rtl/regfld_store.sv
// Field flops with selectable reset timing and polarity
module regfld_store #(
    parameter int               FIELD_W   = 16,
    parameter bit               RST_ASYNC = 1'b0,
    parameter bit               RST_LOW   = 1'b0,
    parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] d,
    output logic [FIELD_W-1:0] q
);
    if (RST_ASYNC && RST_LOW) begin : g_async_low
        always_ff @(posedge clk or negedge rst) begin
            if (!rst) q <= RST_VAL;
            else      q <= d;
        end
    end else if (RST_ASYNC) begin : g_async_high
        always_ff @(posedge clk or posedge rst) begin
            if (rst) q <= RST_VAL;
            else     q <= d;
        end
    end else begin : g_sync
        logic rst_act;
        assign rst_act = rst ^ RST_LOW;
        always_ff @(posedge clk) begin
            if (rst_act) q <= RST_VAL;
            else         q <= d;
        end
    end
endmodule

// File: rtl/regfld_top.sv
module regfld_top
    import regfld_pkg::*;
#(
    parameter int                 BUS_W     = 32,
    parameter int                 FIELD_LSB = 4,
    parameter int                 FIELD_W   = 16,
    parameter wr_effect_e         WR_EFFECT = WR_PLAIN,
    parameter rd_effect_e         RD_EFFECT = RD_NONE,
    parameter hw_mode_e           HW_MODE   = HW_EN_HIGH,
    parameter prec_e              PREC      = PREC_SW,
    parameter bit                 PULSE     = 1'b0,
    parameter bit                 RST_ASYNC = 1'b0,
    parameter bit                 RST_LOW   = 1'b0,
    parameter logic [FIELD_W-1:0] RST_VAL   = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BUS_W-1:0]   sw_wdata,
    input  logic [BUS_W/8-1:0] sw_be,
    input  logic               sw_wr,
    input  logic               sw_rd,
    input  logic [FIELD_W-1:0] hw_in,
    input  logic               hw_we,
    output logic [FIELD_W-1:0] hw_out
);
    localparam logic [FIELD_W-1:0] RD_VAL = (RD_EFFECT == RD_SET) ? '1 : '0;

    req_t               req;
    logic [FIELD_W-1:0] q_field;
    logic [FIELD_W-1:0] sw_val;
    logic [FIELD_W-1:0] d_field;

    always_comb begin
        req.sw = sw_wr && (WR_EFFECT != WR_NONE);
        req.rd = sw_rd && (RD_EFFECT != RD_NONE);
        case (HW_MODE)
            HW_ALWAYS:  req.hw = 1'b1;
            HW_EN_HIGH: req.hw = hw_we;
            HW_EN_LOW:  req.hw = !hw_we;
            default:    req.hw = 1'b0;
        endcase
    end

    regfld_sw_path #(
        .BUS_W    (BUS_W),
        .FIELD_LSB(FIELD_LSB),
        .FIELD_W  (FIELD_W),
        .WR_EFFECT(WR_EFFECT)
    ) u_sw_path (
        .q    (q_field),
        .wdata(sw_wdata),
        .be   (sw_be),
        .nxt  (sw_val)
    );

    regfld_prio #(
        .FIELD_W(FIELD_W),
        .PREC   (PREC),
        .PULSE  (PULSE)
    ) u_prio (
        .req   (req),
        .q     (q_field),
        .sw_val(sw_val),
        .rd_val(RD_VAL),
        .hw_val(hw_in),
        .nxt   (d_field)
    );

    regfld_store #(
        .FIELD_W  (FIELD_W),
        .RST_ASYNC(RST_ASYNC),
        .RST_LOW  (RST_LOW),
        .RST_VAL  (RST_VAL)
    ) u_store (
        .clk(clk),
        .rst(rst),
        .d  (d_field),
        .q  (q_field)
    );

    assign hw_out = q_field;
endmodule

// File: rtl/regfld_chk.sv
module regfld_chk
    import regfld_pkg::*;
#(
    parameter int                 FIELD_W   = 16,
    parameter wr_effect_e         WR_EFFECT = WR_PLAIN,
    parameter rd_effect_e         RD_EFFECT = RD_NONE,
    parameter hw_mode_e           HW_MODE   = HW_EN_HIGH,
    parameter prec_e              PREC      = PREC_SW,
    parameter bit                 PULSE     = 1'b0,
    parameter bit                 RST_LOW   = 1'b0,
    parameter logic [FIELD_W-1:0] RST_VAL   = '0
) (
    input logic               clk,
    input logic               rst,
    input logic               sw_wr,
    input logic               sw_rd,
    input logic [FIELD_W-1:0] hw_in,
    input logic               hw_we,
    input logic [FIELD_W-1:0] hw_out
);
    logic rst_act, c_sw, c_rd, c_hw, hw_wins;

    always_comb begin
        rst_act = RST_LOW ? !rst : rst;
        c_sw    = sw_wr && (WR_EFFECT != WR_NONE);
        c_rd    = sw_rd && (RD_EFFECT != RD_NONE);
        c_hw    = (HW_MODE == HW_ALWAYS)
               || (HW_MODE == HW_EN_HIGH && hw_we)
               || (HW_MODE == HW_EN_LOW && !hw_we);
        hw_wins = c_hw && ((PREC == PREC_HW) || (!c_sw && !c_rd));
    end

    // R1: reset loads the reset value at the next edge
    p_reset_load_r1: assert property (@(posedge clk)
        rst_act |=> hw_out == RST_VAL);

    // R7 and R9: a winning hardware write lands the input value
    p_hw_load_r7: assert property (@(posedge clk) disable iff (rst_act)
        hw_wins |=> hw_out == $past(hw_in));

    // R11: no request means the field holds
    p_hold_r11: assert property (@(posedge clk) disable iff (rst_act)
        (!c_sw && !c_rd && !c_hw && !PULSE) |=> $stable(hw_out));

    if (PULSE) begin : g_pulse
        // R10: idle cycle returns the field to zero
        p_pulse_zero_r10: assert property (@(posedge clk) disable iff (rst_act)
            (!c_sw && !c_rd && !c_hw) |=> hw_out == '0);
    end

    if (RD_EFFECT != RD_NONE) begin : g_rd
        // R6: read side-effect when nothing above it competes
        p_rd_effect_r6: assert property (@(posedge clk) disable iff (rst_act)
            (c_rd && !c_sw && !(PREC == PREC_HW && c_hw)) |=>
            hw_out == ((RD_EFFECT == RD_SET) ? {FIELD_W{1'b1}} : {FIELD_W{1'b0}}));
    end

    if (WR_EFFECT == WR_CLRALL || WR_EFFECT == WR_SETALL) begin : g_all
        // R5: whole-field write effect regardless of lanes
        p_whole_field_r5: assert property (@(posedge clk) disable iff (rst_act)
            (c_sw && !(PREC == PREC_HW && c_hw)) |=>
            hw_out == ((WR_EFFECT == WR_SETALL) ? {FIELD_W{1'b1}} : {FIELD_W{1'b0}}));
    end
endmodule

bind regfld_top regfld_chk #(
    .FIELD_W  (FIELD_W),
    .WR_EFFECT(WR_EFFECT),
    .RD_EFFECT(RD_EFFECT),
    .HW_MODE  (HW_MODE),
    .PREC     (PREC),
    .PULSE    (PULSE),
    .RST_LOW  (RST_LOW),
    .RST_VAL  (RST_VAL)
) u_regfld_chk (
    .clk   (clk),
    .rst   (rst),
    .sw_wr (sw_wr),
    .sw_rd (sw_rd),
    .hw_in (hw_in),
    .hw_we (hw_we),
    .hw_out(hw_out)
);

// File: tb/test_regfld_top.sv
`timescale 1ns/100ps
module test_regfld_top;
    import regfld_pkg::*;

    localparam wr_effect_e FX[9] = '{WR_NONE, WR_PLAIN, WR_SET1, WR_CLR1, WR_TGL1,
                                     WR_SET0, WR_TGL0, WR_CLRALL, WR_SETALL};
    localparam logic [15:0] RV_FX = 16'h5A3C;
    localparam logic [11:0] RV_A  = 12'h9E1;
    localparam logic [11:0] RV_B  = 12'h000;
    localparam logic [7:0]  RV_C  = 8'h81;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_n = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_be = '0;
    logic        s_wr = 1'b0;
    logic        s_rd = 1'b0;
    logic [31:0] s_hin = '0;
    logic        s_hwe = 1'b0;

    logic [15:0] fx_out [9];
    logic [11:0] out_a, out_b;
    logic [7:0]  out_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    for (genvar g = 0; g < 9; g++) begin : g_fx
        regfld_top #(
            .BUS_W(32), .FIELD_LSB(4), .FIELD_W(16), .WR_EFFECT(FX[g]),
            .RD_EFFECT(RD_NONE), .HW_MODE(HW_EN_HIGH), .PREC(PREC_SW),
            .PULSE(1'b0), .RST_ASYNC(1'b0), .RST_LOW(1'b0), .RST_VAL(RV_FX)
        ) i_fx (
            .clk(clk), .rst(rst), .sw_wdata(s_wdata), .sw_be(s_be), .sw_wr(s_wr),
            .sw_rd(s_rd), .hw_in(s_hin[15:0]), .hw_we(s_hwe), .hw_out(fx_out[g])
        );
    end

    regfld_top #(
        .BUS_W(32), .FIELD_LSB(10), .FIELD_W(12), .WR_EFFECT(WR_PLAIN),
        .RD_EFFECT(RD_CLR), .HW_MODE(HW_EN_LOW), .PREC(PREC_HW),
        .PULSE(1'b0), .RST_ASYNC(1'b1), .RST_LOW(1'b1), .RST_VAL(RV_A)
    ) i_regfld_top (
        .clk(clk), .rst(rst_n), .sw_wdata(s_wdata), .sw_be(s_be), .sw_wr(s_wr),
        .sw_rd(s_rd), .hw_in(s_hin[11:0]), .hw_we(s_hwe), .hw_out(out_a)
    );

    regfld_top #(
        .BUS_W(32), .FIELD_LSB(20), .FIELD_W(12), .WR_EFFECT(WR_SET0),
        .RD_EFFECT(RD_SET), .HW_MODE(HW_ALWAYS), .PREC(PREC_SW),
        .PULSE(1'b0), .RST_ASYNC(1'b0), .RST_LOW(1'b0), .RST_VAL(RV_B)
    ) i_regfld_top_b (
        .clk(clk), .rst(rst), .sw_wdata(s_wdata), .sw_be(s_be), .sw_wr(s_wr),
        .sw_rd(s_rd), .hw_in(s_hin[11:0]), .hw_we(s_hwe), .hw_out(out_b)
    );

    regfld_top #(
        .BUS_W(32), .FIELD_LSB(0), .FIELD_W(8), .WR_EFFECT(WR_SET1),
        .RD_EFFECT(RD_NONE), .HW_MODE(HW_NONE), .PREC(PREC_SW),
        .PULSE(1'b1), .RST_ASYNC(1'b0), .RST_LOW(1'b0), .RST_VAL(RV_C)
    ) i_regfld_top_c (
        .clk(clk), .rst(rst), .sw_wdata(s_wdata), .sw_be(s_be), .sw_wr(s_wr),
        .sw_rd(s_rd), .hw_in(s_hin[7:0]), .hw_we(s_hwe), .hw_out(out_c)
    );

    // Reference next value from the requirements
    function automatic logic [31:0] model(wr_effect_e eff, rd_effect_e rde, hw_mode_e hwm,
                                          prec_e prec, bit pulse, int lsb, int w,
                                          logic [31:0] cur, output string tag);
        logic [31:0] mask;
        logic [31:0] swv;
        logic hw_a, sw_a, rd_a;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        swv  = cur;
        for (int k = 0; k < w; k++) begin
            logic b, en, q;
            b  = s_wdata[lsb + k];
            en = s_be[(lsb + k) / 8];
            q  = cur[k];
            case (eff)
                WR_PLAIN:  swv[k] = en ? b : q;
                WR_SET1:   swv[k] = q | (en & b);
                WR_CLR1:   swv[k] = q & ~(en & b);
                WR_TGL1:   swv[k] = q ^ (en & b);
                WR_SET0:   swv[k] = en ? (q & b) : q;
                WR_TGL0:   swv[k] = en ? ~(q ^ b) : q;
                WR_CLRALL: swv[k] = 1'b0;
                WR_SETALL: swv[k] = 1'b1;
                default:   swv[k] = q;
            endcase
        end
        hw_a = (hwm == HW_ALWAYS) || (hwm == HW_EN_HIGH && s_hwe) || (hwm == HW_EN_LOW && !s_hwe);
        sw_a = s_wr && (eff != WR_NONE);
        rd_a = s_rd && (rde != RD_NONE);
        if (prec == PREC_HW && hw_a) begin
            tag = "R9";
            return s_hin & mask;
        end
        if (sw_a) begin
            if (hw_a || rd_a)                          tag = "R8";
            else if (eff == WR_PLAIN)                  tag = "R2";
            else if (eff == WR_SET0 || eff == WR_TGL0) tag = "R4";
            else if (eff == WR_CLRALL || eff == WR_SETALL) tag = "R5";
            else                                       tag = "R3";
            return swv & mask;
        end
        if (rd_a) begin
            tag = hw_a ? "R8" : "R6";
            return (rde == RD_SET) ? mask : 32'd0;
        end
        if (hw_a) begin
            tag = "R7";
            return s_hin & mask;
        end
        if (pulse) begin
            tag = "R10";
            return 32'd0;
        end
        tag = "R11";
        return cur & mask;
    endfunction

    logic [31:0] e_fx [9];
    logic [31:0] e_a, e_b, e_c;
    string t_fx [9];
    string t_a, t_b, t_c;

    task automatic chk(string tag, string who, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    // Inputs are already driven; compute expectations, then compare after the edge
    task automatic step();
        for (int i = 0; i < 9; i++) begin
            if (rst) begin e_fx[i] = {16'd0, RV_FX}; t_fx[i] = "R1"; end
            else e_fx[i] = model(FX[i], RD_NONE, HW_EN_HIGH, PREC_SW, 1'b0, 4, 16, e_fx[i], t_fx[i]);
        end
        if (!rst_n) begin e_a = {20'd0, RV_A}; t_a = "R1"; end
        else e_a = model(WR_PLAIN, RD_CLR, HW_EN_LOW, PREC_HW, 1'b0, 10, 12, e_a, t_a);
        if (rst) begin e_b = {20'd0, RV_B}; t_b = "R1"; e_c = {24'd0, RV_C}; t_c = "R1"; end
        else begin
            e_b = model(WR_SET0, RD_SET, HW_ALWAYS, PREC_SW, 1'b0, 20, 12, e_b, t_b);
            e_c = model(WR_SET1, RD_NONE, HW_NONE, PREC_SW, 1'b1, 0, 8, e_c, t_c);
        end
        @(negedge clk);
        for (int i = 0; i < 9; i++) chk(t_fx[i], $sformatf("fx%0d", i), {16'd0, fx_out[i]}, e_fx[i]);
        chk(t_a, "a", {20'd0, out_a}, e_a);
        chk(t_b, "b", {20'd0, out_b}, e_b);
        chk(t_c, "c", {24'd0, out_c}, e_c);
    endtask

    task automatic drive_random();
        s_wdata = $urandom;
        s_be    = 4'($urandom);
        s_wr    = ($urandom % 3) == 0;
        s_rd    = ($urandom % 4) == 0;
        s_hin   = $urandom;
        s_hwe   = 1'($urandom);
    endtask

    task automatic drive(logic wr, logic rd, logic [3:0] be, logic [31:0] wd, logic hwe);
        s_wr = wr; s_rd = rd; s_be = be; s_wdata = wd; s_hwe = hwe; s_hin = $urandom;
    endtask

    initial begin
        void'($urandom(32'd7731));
        @(negedge clk);
        // R1: reset state on every configuration
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 400; i++) begin drive_random(); step(); end
        // R2/R5: write with no lanes enabled
        drive(1'b1, 1'b0, 4'b0000, 32'hFFFF_FFFF, 1'b0); step();
        // R2: only lane 1 enabled, bus all ones; then only lane 2, bus zero
        drive(1'b1, 1'b0, 4'b0010, 32'hFFFF_FFFF, 1'b0); step();
        drive(1'b1, 1'b0, 4'b0100, 32'h0000_0000, 1'b0); step();
        // R6: read strobe alone
        drive(1'b0, 1'b1, 4'b0000, 32'd0, 1'b1); step();
        // R11: idle cycles
        drive(1'b0, 1'b0, 4'b1111, 32'hA5A5_A5A5, 1'b0); step(); step();
        // R12: asynchronous reset takes effect between edges
        drive(1'b0, 1'b0, 4'b0000, 32'd0, 1'b1);
        #0.5 rst_n = 1'b0;
        #0.5 chk("R12", "a_async", {20'd0, out_a}, {20'd0, RV_A});
        step();
        rst_n = 1'b1;
        // R1: synchronous reset mid-run
        drive_random(); rst = 1'b1; step();
        rst = 1'b0;
        for (int i = 0; i < 1200; i++) begin drive_random(); step(); end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before the run ended");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule